// File: doc/BRIEF.md
# Synchronous Serial Port, Master or Slave

This block is a byte-wide synchronous serial port behind a small register interface. Software selects the role and clock rate, the bit order and the chip-select use in a control register. It then writes a byte to the data register to start a frame. As master, the port divides the system clock to make the serial clock and drives chip-select low around the frame. As slave, it follows an external serial clock after passing it, chip-select and the serial input through two-flop synchronisers.

Each frame is 8 bits. Every bit is sampled on the clock edge that leaves the idle level and changed on the edge that returns to it. At the end of a frame the shift buffer is copied into the data register, and a sticky completion flag raises the interrupt level. A data write made while a frame is running is dropped and recorded in a sticky collision flag. Software clears both flags by writing ones to the status register. Pins are modelled as value-plus-enable pairs, and the enables fall to zero whenever the port is disabled.

Top module: `spiPort`

Register map (write and read, 8-bit data):
- address 0, data: a write starts a frame, and a read returns the last received byte.
- address 1, control: bits [1:0] select the role and rate, bit 2 set means LSB first, bit 3 is the chip-select enable and bit 4 is the port enable.
- address 2, status: bit 0 is frame done and bit 1 is collision. Writing 1 to a bit clears it.

## Requirements
- R1: After reset all registers read 0, the interrupt output is 0 and the sckOe, sdoOe and csOe pin enables are 0.
- R2: While the port enable (control bit 4) is 0, the sckOe, sdoOe and csOe enables are 0. Clearing the enable during a frame abandons that frame, and no done flag is raised for it.
- R3: While the port is enabled and idle, sdoO is driven to 1. In master roles sckO is driven at the idle level CPOL_IDLE, and csO is driven high when chip-select is enabled. In the slave role (code 11) sckOe is 0. csOe is 0 when chip-select is disabled.
- R4: Role codes 00, 01 and 10 make the port master, with each serial clock level held for 1, 4 and 16 system clocks respectively (divide by 2, 8 and 32). Each frame has exactly 8 leading edges.
- R5: With control bit 2 at 0 the MSB moves first, and with it at 1 the LSB moves first, in both directions. The input is sampled on the leading edge and the output changes on the trailing edge.
- R6: With chip-select enabled, the master drives csO low from the data write until the last edge, so csO is already low at the first clock edge. It drives csO high again afterwards.
- R7: At the end of a frame the received byte appears at address 0, status bit 0 sets and the interrupt goes high. These stay until software writes 1 to status bit 0.
- R8: A data write while a frame runs, in either role, changes neither the byte being sent nor the frame, and sets status bit 1 until software writes 1 to it.
- R9: In the slave role the port shifts on the synchronised external clock. With chip-select enabled, clock edges seen while csI is high are ignored, and a deasserted csI abandons a partial frame.
- R10: When the build option CS_OPTION is 0, chip-select behaves as disabled whatever control bit 3 holds, so csOe stays 0.
- R11: When the build option COLLISION_EN is 0, a data write during a frame is still dropped but status bit 1 never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| sckI | input | 1 | Serial clock pin input (slave role) |
| sckO | output | 1 | Serial clock pin value (master role) |
| sckOe | output | 1 | Serial clock pin drive enable |
| sdiI | input | 1 | Serial data input pin |
| sdoO | output | 1 | Serial data output pin value |
| sdoOe | output | 1 | Serial data output drive enable |
| csI | input | 1 | Chip-select pin input, active low (slave role) |
| csO | output | 1 | Chip-select pin value, active low (master role) |
| csOe | output | 1 | Chip-select pin drive enable |
| irq | output | 1 | Serial interrupt level, equal to the done flag |

## Verification
Master frames run in all three rate codes. They pair MSB-first and LSB-first orders with asymmetric transmit and receive bytes, so that a reversed bit order, a wrong divider or a swapped sample edge each give a distinct mismatch in the captured output byte, the received byte or the measured half-period. Slave frames run with and without chip-select. A burst of clock edges with chip-select high must leave no trace on the next frame. A write in the middle of a slow master frame shows whether the dropped byte leaks into the output stream. A second instance built without the chip-select and collision options shows that those options really switch the features off.

// File: rtl/spiPortPkg.sv
package spiPortPkg;

  typedef struct packed {
    logic       enable;
    logic       csEn;
    logic       lsbFirst;
    logic [1:0] mode;
  } portCfg_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic done;
    logic collide;
  } ctrlStrb_t;

  localparam logic [1:0] MODE_SLAVE = 2'b11;
  localparam logic [1:0] ADDR_DATA  = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;

endpackage

// File: rtl/spiPortData.sv
module spiPortData
  import spiPortPkg::*;
#(
  parameter int DATA_W       = 8,
  parameter bit COLLISION_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sdiPin,
  input  ctrlStrb_t         strb,
  output portCfg_t          cfg,
  output logic              dataWr,
  output logic              txBit,
  output logic              loaded,
  output logic              doneFlag
);

  localparam int CFG_W = $bits(portCfg_t);

  logic [DATA_W-1:0] dataReg, shiftReg, shiftNext;
  logic rxBit, collFlag, sdiMeta, sdiSync, rxSrc, statWr;

  assign dataWr = wrEn && (wrAddr == ADDR_DATA);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);

  // slave samples the synchronised pin so it lines up with the synchronised clock
  assign rxSrc = (cfg.mode == MODE_SLAVE) ? sdiSync : sdiPin;

  assign shiftNext = cfg.lsbFirst ? {rxBit, shiftReg[DATA_W-1:1]}
                                  : {shiftReg[DATA_W-2:0], rxBit};
  assign txBit = cfg.lsbFirst ? shiftReg[0] : shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= '0;
      dataReg  <= '0;
      shiftReg <= '0;
      rxBit    <= 1'b0;
      loaded   <= 1'b0;
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      sdiMeta  <= 1'b1;
      sdiSync  <= 1'b1;
    end else begin
      sdiMeta <= sdiPin;
      sdiSync <= sdiMeta;
      if (wrEn && (wrAddr == ADDR_CTRL)) cfg <= portCfg_t'(wrData[CFG_W-1:0]);
      if (strb.sample) rxBit <= rxSrc;
      if (strb.load) shiftReg <= wrData;
      else if (strb.shift) shiftReg <= shiftNext;
      if (strb.done) dataReg <= shiftNext;
      if (!cfg.enable) loaded <= 1'b0;
      else if (strb.load) loaded <= 1'b1;
      else if (strb.done) loaded <= 1'b0;
      if (strb.done) doneFlag <= 1'b1;
      else if (statWr && wrData[0]) doneFlag <= 1'b0;
      if (COLLISION_EN && strb.collide) collFlag <= 1'b1;
      else if (statWr && wrData[1]) collFlag <= 1'b0;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_DATA: rdData = dataReg;
      ADDR_CTRL: rdData = {{(DATA_W-CFG_W){1'b0}}, cfg};
      ADDR_STAT: rdData = {{(DATA_W-2){1'b0}}, collFlag, doneFlag};
      default:   rdData = '0;
    endcase
  end

  // R7: completion sets the sticky flag, and only a clearing write drops it
  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> doneFlag);
  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(statWr && wrData[0])) |=> doneFlag);
  // R8: a dropped write raises the collision flag
  p_collide_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((COLLISION_EN != 0) && strb.collide) |=> collFlag);
  // R11: no collision flag when the feature is built out
  p_no_collide_r11: assert property (@(posedge clk) disable iff (!rstN)
    (COLLISION_EN == 0) |-> !collFlag);

endmodule

// File: rtl/spiPortCtrl.sv
module spiPortCtrl
  import spiPortPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HALF_A    = 1,
  parameter int HALF_B    = 4,
  parameter int HALF_C    = 16,
  parameter bit CPOL_IDLE = 1'b0,
  parameter bit CS_OPTION = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       csEn,
  input  logic [1:0] mode,
  input  logic       dataWr,
  input  logic       sckPin,
  input  logic       csPin,
  output ctrlStrb_t  strb,
  output logic       isMaster,
  output logic       csActive,
  output logic       sckLevel,
  output logic       csAssert
);

  localparam int EDGES    = 2 * DATA_W;
  localparam int EDGE_W   = $clog2(EDGES);
  localparam int HALF_AB  = (HALF_A > HALF_B) ? HALF_A : HALF_B;
  localparam int HALF_MAX = (HALF_AB > HALF_C) ? HALF_AB : HALF_C;
  localparam int DIV_W    = $clog2(HALF_MAX + 1);

  logic [DIV_W-1:0]  divCnt, halfSel;
  logic [EDGE_W-1:0] edgeCnt;
  logic masterRun, tick, lastEdge, busy;
  logic sckMeta, sckSync, sckPrev, csMeta, csSync;
  logic slaveOn, sckEdge;

  assign isMaster = (mode != MODE_SLAVE);
  assign csActive = csEn && CS_OPTION;
  assign csAssert = csActive && isMaster && masterRun;

  always_comb begin
    case (mode)
      2'b00:   halfSel = DIV_W'(HALF_A);
      2'b01:   halfSel = DIV_W'(HALF_B);
      default: halfSel = DIV_W'(HALF_C);
    endcase
  end

  assign tick     = masterRun && (divCnt == halfSel - DIV_W'(1));
  assign lastEdge = (edgeCnt == EDGE_W'(EDGES - 1));
  assign busy     = isMaster ? masterRun : (edgeCnt != '0);
  assign slaveOn  = enable && !isMaster && (!csActive || !csSync);
  assign sckEdge  = (sckSync != sckPrev);

  always_comb begin
    strb = '0;
    if (enable && dataWr) begin
      if (busy) strb.collide = 1'b1;
      else      strb.load    = 1'b1;
    end
    if (tick) begin
      if (!edgeCnt[0]) strb.sample = 1'b1;
      else             strb.shift  = 1'b1;
      strb.done = lastEdge;
    end
    if (slaveOn && sckEdge) begin
      if ((sckSync != CPOL_IDLE) && !edgeCnt[0]) strb.sample = 1'b1;
      if ((sckSync == CPOL_IDLE) && edgeCnt[0]) begin
        strb.shift = 1'b1;
        strb.done  = lastEdge;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckMeta <= CPOL_IDLE;
      sckSync <= CPOL_IDLE;
      sckPrev <= CPOL_IDLE;
      csMeta  <= 1'b1;
      csSync  <= 1'b1;
    end else begin
      sckMeta <= sckPin;
      sckSync <= sckMeta;
      sckPrev <= sckSync;
      csMeta  <= csPin;
      csSync  <= csMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterRun <= 1'b0;
      divCnt    <= '0;
      edgeCnt   <= '0;
      sckLevel  <= CPOL_IDLE;
    end else if (!enable) begin
      masterRun <= 1'b0;
      divCnt    <= '0;
      edgeCnt   <= '0;
      sckLevel  <= CPOL_IDLE;
    end else if (isMaster) begin
      if (strb.load) begin
        masterRun <= 1'b1;
        divCnt    <= '0;
        edgeCnt   <= '0;
        sckLevel  <= CPOL_IDLE;
      end else if (tick) begin
        divCnt   <= '0;
        sckLevel <= ~sckLevel;
        edgeCnt  <= lastEdge ? '0 : edgeCnt + EDGE_W'(1);
        if (lastEdge) masterRun <= 1'b0;
      end else if (masterRun) begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end else begin
      masterRun <= 1'b0;
      sckLevel  <= CPOL_IDLE;
      if (csActive && csSync)  edgeCnt <= '0;
      else if (strb.sample)    edgeCnt <= edgeCnt + EDGE_W'(1);
      else if (strb.shift)     edgeCnt <= lastEdge ? '0 : edgeCnt + EDGE_W'(1);
    end
  end

  // R3: an idle master rests the clock at the polarity level
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    !masterRun |-> (sckLevel == CPOL_IDLE));
  // R4: before each leading edge the clock sits at the idle level
  p_even_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (masterRun && !edgeCnt[0]) |-> (sckLevel == CPOL_IDLE));
  // R6: every master clock movement happens with chip-select already low
  p_cs_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && csActive && (sckLevel != $past(sckLevel))) |-> $past(csAssert));

endmodule

// File: rtl/spiPort.sv
module spiPort
  import spiPortPkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int HALF_A       = 1,
  parameter int HALF_B       = 4,
  parameter int HALF_C       = 16,
  parameter bit CPOL_IDLE    = 1'b0,
  parameter bit CS_OPTION    = 1'b1,
  parameter bit COLLISION_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckI,
  output logic              sckO,
  output logic              sckOe,
  input  logic              sdiI,
  output logic              sdoO,
  output logic              sdoOe,
  input  logic              csI,
  output logic              csO,
  output logic              csOe,
  output logic              irq
);

  portCfg_t  cfg;
  ctrlStrb_t strb;
  logic dataWr, txBit, loaded, doneFlag;
  logic isMaster, csActive, sckLevel, csAssert;

  spiPortData #(
    .DATA_W(DATA_W), .COLLISION_EN(COLLISION_EN)
  ) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sdiPin(sdiI), .strb(strb), .cfg(cfg),
    .dataWr(dataWr), .txBit(txBit), .loaded(loaded), .doneFlag(doneFlag)
  );

  spiPortCtrl #(
    .DATA_W(DATA_W), .HALF_A(HALF_A), .HALF_B(HALF_B), .HALF_C(HALF_C),
    .CPOL_IDLE(CPOL_IDLE), .CS_OPTION(CS_OPTION)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(cfg.enable), .csEn(cfg.csEn), .mode(cfg.mode),
    .dataWr(dataWr), .sckPin(sckI), .csPin(csI), .strb(strb), .isMaster(isMaster),
    .csActive(csActive), .sckLevel(sckLevel), .csAssert(csAssert)
  );

  assign sckO  = sckLevel;
  assign sckOe = cfg.enable && isMaster;
  assign sdoO  = loaded ? txBit : 1'b1;
  assign sdoOe = cfg.enable;
  assign csO   = !csAssert;
  assign csOe  = cfg.enable && isMaster && csActive;
  assign irq   = doneFlag;

  // R2: a disabled port drives no pin
  p_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> (!sckOe && !sdoOe && !csOe));
  // R10: with the build option off, chip-select is never driven
  p_cs_option_r10: assert property (@(posedge clk) disable iff (!rstN)
    (CS_OPTION == 0) |-> !csOe);

endmodule

// File: tb/tb_spiPort.sv
module tb_spiPort;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] tx;
    int         half;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic sckI = 1'b0, csI = 1'b1, sSdi = 1'b1, sdiI;
  logic [7:0] rdData, rdData2;
  logic sckO, sckOe, sdoO, sdoOe, csO, csOe, irq;
  logic sckO2, sckOe2, sdoO2, sdoOe2, csO2, csOe2, irq2;

  int total = 0, fails = 0, monChecks = 0, monFails = 0;
  exp_t q[$];

  // capture state (written only by the capture process)
  logic benchMaster = 1'b1, lsbSel = 1'b0;
  logic [7:0] rxPat = '0, capTx = '0, sCapTx = '0;
  int bitIdx = 0, leadCnt = 0, chgCnt = 0, gapCnt = 0, minGap = 999, maxGap = 0, csBad = 0;
  logic prevSck = 1'b0;
  int armReq = 0, armAck = 0;

  always #4 clk = ~clk;

  spiPort dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sckI(sckI), .sckO(sckO), .sckOe(sckOe),
    .sdiI(sdiI), .sdoO(sdoO), .sdoOe(sdoOe), .csI(csI), .csO(csO), .csOe(csOe), .irq(irq)
  );

  spiPort #(.CS_OPTION(1'b0), .COLLISION_EN(1'b0)) dut2 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData2), .sckI(sckI), .sckO(sckO2), .sckOe(sckOe2),
    .sdiI(sdiI), .sdoO(sdoO2), .sdoOe(sdoOe2), .csI(csI), .csO(csO2), .csOe(csOe2), .irq(irq2)
  );

  always_comb begin
    if (benchMaster) sdiI = (bitIdx < 8) ? (lsbSel ? rxPat[bitIdx] : rxPat[7-bitIdx]) : 1'b1;
    else             sdiI = sSdi;
  end

  // bench slave for master frames: feeds sdi on trailing edges, records sdo on leading ones
  always @(negedge clk) begin
    if (armReq != armAck) begin
      armAck = armReq; bitIdx = 0; leadCnt = 0; chgCnt = 0; gapCnt = 0;
      minGap = 999; maxGap = 0; csBad = 0; capTx = '0;
    end else if (benchMaster && rstN) begin
      gapCnt++;
      if (sckO != prevSck) begin
        if (chgCnt > 0) begin
          if (gapCnt < minGap) minGap = gapCnt;
          if (gapCnt > maxGap) maxGap = gapCnt;
        end
        chgCnt++;
        gapCnt = 0;
        if (sckO != 1'b0) begin
          if (!(csOe && !csO)) csBad++;
          capTx = lsbSel ? {sdoO, capTx[7:1]} : {capTx[6:0], sdoO};
          leadCnt++;
        end else begin
          bitIdx++;
        end
      end
    end
    prevSck = sckO;
  end

  // monitor: pops an expected frame on each rising interrupt
  logic irqPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && irq && !irqPrev) begin
      if (q.size() == 0) begin
        monChecks++; monFails++;
        $display("FAIL R7/R9: unexpected frame completion, got irq 1 expected 0");
      end else begin
        exp_t e;
        logic [7:0] gotTx;
        e = q.pop_front();
        gotTx = (e.half > 0) ? capTx : sCapTx;
        monChecks++;
        if (rdData !== e.rx) begin
          monFails++;
          $display("FAIL %s: received byte got %02h expected %02h", e.req, rdData, e.rx);
        end
        monChecks++;
        if (gotTx !== e.tx) begin
          monFails++;
          $display("FAIL %s: sent byte got %02h expected %02h", e.req, gotTx, e.tx);
        end
        if (e.half > 0) begin
          monChecks++;
          if (minGap != e.half || maxGap != e.half || leadCnt != 8) begin
            monFails++;
            $display("FAIL %s: half period min %0d max %0d leads %0d expected %0d/%0d/8",
                     e.req, minGap, maxGap, leadCnt, e.half, e.half);
          end
        end
      end
    end
    irqPrev = irq;
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [7:0] v, output logic [7:0] v2);
    @(negedge clk); rdAddr = a; #1; v = rdData; v2 = rdData2; rdAddr = 2'd0;
  endtask

  task automatic waitIrq(string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(req, "frame completion", int'(irq), 1);
  endtask

  // driver for master frames; ctrl = enable | csEn | order | mode
  task automatic masterXfer(logic [1:0] mode, logic lsb, logic [7:0] tx, logic [7:0] rx,
                            int half, string req);
    exp_t e;
    benchMaster = 1'b1;
    wrReg(2'd1, {3'b000, 1'b1, 1'b1, lsb, mode});
    rxPat = rx; lsbSel = lsb; armReq++;
    @(negedge clk);
    e.rx = rx; e.tx = tx; e.half = half; e.req = req;
    q.push_back(e);
    wrReg(2'd0, tx);
  endtask

  task automatic finishMaster(string req);
    waitIrq(req);
    chk("R6", "chip-select low at every leading edge (violations)", csBad, 0);
    chk("R6", "chip-select released after frame", int'(csO), 1);
  endtask

  task automatic clearFlags();
    wrReg(2'd2, 8'h03);
  endtask

  task automatic slaveXfer(logic lsb, logic [7:0] tx, logic [7:0] rx, logic useCs, string req);
    exp_t e;
    benchMaster = 1'b0;
    wrReg(2'd1, {3'b000, 1'b1, useCs, lsb, 2'b11});
    e.rx = rx; e.tx = tx; e.half = 0; e.req = req;
    q.push_back(e);
    sCapTx = '0;
    wrReg(2'd0, tx);
    @(negedge clk);
    if (useCs) csI = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sSdi = lsb ? rx[i] : rx[7-i];
      repeat (6) @(negedge clk);
      sCapTx = lsb ? {sdoO, sCapTx[7:1]} : {sCapTx[6:0], sdoO};
      sckI = 1'b1;
      repeat (6) @(negedge clk);
      sckI = 1'b0;
    end
    repeat (6) @(negedge clk);
    csI = 1'b1;
    waitIrq(req);
    clearFlags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", (total + monChecks) - (fails + monFails) - 1,
             total + monChecks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "pin enables", int'({sckOe, sdoOe, csOe}), 0);
    chk("R1", "irq", int'(irq), 0);
    rdReg(2'd0, v, v2); chk("R1", "data reg", v, 0);
    rdReg(2'd1, v, v2); chk("R1", "ctrl reg", v, 0);
    rdReg(2'd2, v, v2); chk("R1", "status reg", v, 0);

    // R3: enabled idle master with chip-select
    wrReg(2'd1, 8'h18);
    @(negedge clk);
    chk("R3", "idle pins {sdoOe,sdoO,sckOe,sckO,csOe,csO}",
        int'({sdoOe, sdoO, sckOe, sckO, csOe, csO}), 6'b111011);
    chk("R10", "csOe without build option", int'(csOe2), 0);
    wrReg(2'd1, 8'h10);
    @(negedge clk);
    chk("R3", "csOe with chip-select off", int'(csOe), 0);
    wrReg(2'd1, 8'h13);
    @(negedge clk);
    chk("R3", "slave sckOe", int'(sckOe), 0);
    chk("R3", "slave idle sdo", int'({sdoOe, sdoO}), 2'b11);

    // R4 R5 R7: fast master, MSB first
    masterXfer(2'b00, 1'b0, 8'hA5, 8'h3C, 1, "R4/R5/R7 mode00 msb");
    finishMaster("R7");
    repeat (40) @(negedge clk);
    chk("R7", "done flag holds", int'(irq), 1);
    wrReg(2'd2, 8'h00);
    chk("R7", "done flag survives zero write", int'(irq), 1);
    rdReg(2'd0, v, v2); chk("R7", "data reg after frame", v, 8'h3C);
    clearFlags();
    @(negedge clk);
    chk("R7", "done flag cleared", int'(irq), 0);

    // R4 R5: divide by 8, LSB first
    masterXfer(2'b01, 1'b1, 8'h1E, 8'hB4, 4, "R4/R5 mode01 lsb");
    finishMaster("R5");
    clearFlags();

    // R5: fast master, LSB first
    masterXfer(2'b00, 1'b1, 8'h0D, 8'h71, 1, "R5 mode00 lsb");
    finishMaster("R5");
    clearFlags();

    // R8 R11: divide by 32, collision mid-frame
    masterXfer(2'b10, 1'b0, 8'hC3, 8'h5A, 16, "R4/R8 mode10 collision");
    repeat (40) @(negedge clk);
    wrReg(2'd0, 8'hFF);
    rdReg(2'd2, v, v2);
    chk("R8", "collision flag", int'(v[1]), 1);
    chk("R11", "collision flag without build option", int'(v2[1]), 0);
    finishMaster("R8");
    rdReg(2'd2, v, v2);
    chk("R8", "collision flag sticky after frame", int'(v[1]), 1);
    clearFlags();
    rdReg(2'd2, v, v2);
    chk("R8", "status cleared", v, 0);

    // R2: disable mid-frame releases pins and abandons the frame
    benchMaster = 1'b1;
    wrReg(2'd1, 8'h1A);
    wrReg(2'd0, 8'h99);
    repeat (30) @(negedge clk);
    wrReg(2'd1, 8'h0A);
    @(negedge clk);
    chk("R2", "disabled pin enables", int'({sckOe, sdoOe, csOe}), 0);
    repeat (600) @(negedge clk);
    chk("R2", "no done for abandoned frame", int'(irq), 0);
    masterXfer(2'b00, 1'b0, 8'h6E, 8'hD2, 1, "R2 fresh frame after abort");
    finishMaster("R2");
    clearFlags();

    // R9: slave ignores clocks while deselected
    benchMaster = 1'b0;
    wrReg(2'd1, 8'h1B);
    csI = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (6) @(negedge clk); sckI = 1'b1;
      repeat (6) @(negedge clk); sckI = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk("R9", "no frame while deselected", int'(irq), 0);

    // R9 R5: slave frames with and without chip-select
    slaveXfer(1'b0, 8'h96, 8'h2B, 1'b1, "R9/R5 slave cs msb");
    slaveXfer(1'b1, 8'h47, 8'hE8, 1'b0, "R9/R5 slave nocs lsb");

    repeat (10) @(negedge clk);
    chk("R7", "all expected frames seen", q.size(), 0);
    $display("%0d/%0d checks passed", (total + monChecks) - (fails + monFails),
             total + monChecks);
    $finish;
  end

endmodule